// File: doc/BRIEF.md
# Dual Split Decade Counter

The block holds a parameterised number of independent 4-bit counters (two by default). Each counter is built from two sections, each with its own count input. A modulo-2 section drives bit 0. A modulo-5 section drives bits 3:1 as a binary value from 0 to 4 and then wraps to 0. A section advances only when its count input goes from high to low. Count inputs are sampled on one system clock, so the block is fully synchronous.

A per-counter link code joins the two sections inside a counter. The options are a BCD decade count, a biquinary count whose bit 0 divides by ten with a 50 % duty cycle, or no link, so that each section runs from its own input. A chain enable links neighbouring counters: each counter then feeds the entry section of the next one, which turns two decade counters into a divide-by-100. Each counter has its own active-low clear. The clear can cut a count short to build divide-by-N stages.

Top module: `dsdc_top`

## Requirements
- R1: A high level of the synchronous reset `rst` at a rising clock edge sets every bit of every counter to 0.
- R2: With link code 0, each high-to-low transition of a counter's `cp_two_i` bit toggles bit 0 of that counter and leaves bits 3:1 unchanged.
- R3: With link code 0, each high-to-low transition of a counter's `cp_five_i` bit steps bits 3:1 through the binary values 0,1,2,3,4,0 and leaves bit 0 unchanged. Rising edges and steady levels have no effect.
- R4: A count input that goes low after at least two rising clock edges at a high level changes the output on the second rising clock edge at which it is seen low, and not before.
- R5: With link code 1 (decade), a 1-to-0 change of bit 0 advances the modulo-5 section one clock later, so that pulses on `cp_two_i` give the BCD sequence 0 to 9 on bits 3:0 and then 0. The external modulo-5 input of that counter is ignored.
- R6: With link code 2 (biquinary), a 1-to-0 change of bit 3 toggles bit 0 one clock later, so that pulses on `cp_five_i` give the values 0,2,4,6,8,1,3,5,7,9,0 on bits 3:0. The external modulo-2 input of that counter is ignored.
- R7: A low level on a counter's `clr_n_i` bit sets that counter to 0 at once, without waiting for a clock. While the level stays low, that counter's count inputs are ignored. The other counters are not affected.
- R8: With `chain_i` high, counter k (k>0) takes its entry count from counter k-1: from the modulo-2 section in link codes 0, 1 and 3, and from the modulo-5 section in code 2. The count source is a 1-to-0 change of bit 3 of counter k-1 in codes 0, 1 and 3, or of bit 0 of counter k-1 in code 2. The external entry input of counter k is then ignored. Two decade counters chained this way count 00 to 99 in BCD.
- R9: Link code 3 behaves as code 0: both sections count from their own external inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; count inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of all counters |
| cp_two_i | input | NUM_CTR | Count input of each counter's modulo-2 section, falling-edge active |
| cp_five_i | input | NUM_CTR | Count input of each counter's modulo-5 section, falling-edge active |
| clr_n_i | input | NUM_CTR | Active-low clear, one bit per counter |
| link_i | input | 2*NUM_CTR | Link code per counter: 0 none, 1 decade, 2 biquinary, 3 none |
| chain_i | input | 1 | Feeds each counter's carry into the next counter's entry section |
| q_o | output | 4*NUM_CTR | Counter values; counter k occupies bits 4k+3:4k |

## Verification
The bench builds the block with NUM_CTR = 3. This puts one counter between the two ends of the chain, so a carry has to pass through a counter that is itself both driven and driving. One hundred decade pulses then reach the third counter. The extra counter also allows mixed chains in which a biquinary counter sits after a decade counter, and gives a spare counter to run with link code 3 while the others stay idle.

// File: rtl/dsdc_pkg.sv
package dsdc_pkg;

    localparam int TWO_MOD  = 2;
    localparam int FIVE_MOD = 5;
    localparam int FIVE_W   = $clog2(FIVE_MOD);
    localparam int CTR_W    = 1 + FIVE_W;

    typedef enum logic [1:0] {
        LINK_SPLIT = 2'd0,
        LINK_BCD   = 2'd1,
        LINK_BIQ   = 2'd2,
        LINK_ALT   = 2'd3
    } link_e;

    // Bit 0 is the modulo-2 section, bits 3:1 the modulo-5 section.
    typedef struct packed {
        logic [FIVE_W-1:0] five;
        logic              two;
    } ctr_val_t;

    typedef struct packed {
        logic two;
        logic five;
    } adv_t;

    function automatic logic fell(logic prev, logic cur);
        return prev & ~cur;
    endfunction

    // In biquinary order the modulo-5 section is entered first.
    function automatic logic entry_is_five(link_e m);
        return m == LINK_BIQ;
    endfunction

endpackage

// File: rtl/dsdc_fall_det.sv
module dsdc_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall_o
);
    logic smp, smp_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp   <= 1'b0;
            smp_d <= 1'b0;
        end else begin
            smp   <= din;
            smp_d <= smp;
        end
    end

    assign fall_o = dsdc_pkg::fell(smp_d, smp);

    // R4: a detected falling transition lasts a single cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/dsdc_section.sv
module dsdc_section #(
    parameter int MOD = 5,
    localparam int W  = (MOD > 2) ? $clog2(MOD) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_n,
    input  logic         hold,
    input  logic         adv,
    output logic [W-1:0] val_o
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)           val_o <= '0;
        else if (rst || hold) val_o <= '0;
        else if (adv)         val_o <= (val_o == LAST) ? '0 : val_o + 1'b1;
    end

    // R3: the section value never leaves its modulus
    a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
        val_o <= LAST);

    // R3: without an advance request the section holds its value
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (!adv && !hold) |=> $stable(val_o));

endmodule

// File: rtl/dsdc_counter.sv
module dsdc_counter
    import dsdc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_n,
    input  link_e    mode,
    input  logic     chain_en,
    input  logic     chain_fall,
    input  logic     cp_two,
    input  logic     cp_five,
    output ctr_val_t q,
    output logic     carry_fall
);
    logic clr_rel, hold;
    logic ext_two_fall, ext_five_fall;
    logic q0_d, q3_d, q0_fall, q3_fall;
    adv_t adv;

    // clear: asserted at once, released on the clock
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) clr_rel <= 1'b0;
        else        clr_rel <= 1'b1;
    end
    assign hold = ~clr_rel;

    dsdc_fall_det u_two_in  (.clk(clk), .rst(rst), .din(cp_two),  .fall_o(ext_two_fall));
    dsdc_fall_det u_five_in (.clk(clk), .rst(rst), .din(cp_five), .fall_o(ext_five_fall));

    // delayed copies of the section outputs for the internal ripple links
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q0_d <= 1'b0;
            q3_d <= 1'b0;
        end else if (rst || hold) begin
            q0_d <= 1'b0;
            q3_d <= 1'b0;
        end else begin
            q0_d <= q.two;
            q3_d <= q.five[FIVE_W-1];
        end
    end
    assign q0_fall = fell(q0_d, q.two);
    assign q3_fall = fell(q3_d, q.five[FIVE_W-1]);

    always_comb begin
        unique case (mode)
            LINK_BCD: begin
                adv.two  = chain_en ? chain_fall : ext_two_fall;
                adv.five = q0_fall;
            end
            LINK_BIQ: begin
                adv.two  = q3_fall;
                adv.five = chain_en ? chain_fall : ext_five_fall;
            end
            default: begin
                adv.two  = chain_en ? chain_fall : ext_two_fall;
                adv.five = ext_five_fall;
            end
        endcase
        carry_fall = entry_is_five(mode) ? q0_fall : q3_fall;
    end

    dsdc_section #(.MOD(TWO_MOD)) u_two (
        .clk(clk), .rst(rst), .clr_n(clr_n), .hold(hold),
        .adv(adv.two), .val_o(q.two)
    );

    dsdc_section #(.MOD(FIVE_MOD)) u_five (
        .clk(clk), .rst(rst), .clr_n(clr_n), .hold(hold),
        .adv(adv.five), .val_o(q.five)
    );

    // R1: the cycle after a reset edge the counter reads zero
    a_r1_reset_zero: assert property (@(posedge clk)
        $past(rst) |-> (q == '0));

    // R7: while clear is low the counter reads zero
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (q == '0));

    // R5: in decade order a falling bit 0 moves the modulo-5 section
    a_r5_bcd_link: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (mode == LINK_BCD && $stable(mode) && clr_rel && $fell(q.two))
        |=> (q.five != $past(q.five)));

    // R6: in biquinary order a falling bit 3 toggles bit 0
    a_r6_biq_link: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (mode == LINK_BIQ && $stable(mode) && clr_rel && $fell(q.five[FIVE_W-1]))
        |=> (q.two != $past(q.two)));

endmodule

// File: rtl/dsdc_top.sv
module dsdc_top
    import dsdc_pkg::*;
#(
    parameter int NUM_CTR = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_CTR-1:0]         cp_two_i,
    input  logic [NUM_CTR-1:0]         cp_five_i,
    input  logic [NUM_CTR-1:0]         clr_n_i,
    input  logic [NUM_CTR-1:0][1:0]    link_i,
    input  logic                       chain_i,
    output logic [NUM_CTR-1:0][CTR_W-1:0] q_o
);
    logic [NUM_CTR-1:0] carry;

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        logic     cf;
        logic     cen;
        ctr_val_t val;

        if (k == 0) begin : g_first
            assign cf  = 1'b0;
            assign cen = 1'b0;
        end else begin : g_next
            assign cf  = carry[k-1];
            assign cen = chain_i;
        end

        dsdc_counter u_ctr (
            .clk        (clk),
            .rst        (rst),
            .clr_n      (clr_n_i[k]),
            .mode       (link_e'(link_i[k])),
            .chain_en   (cen),
            .chain_fall (cf),
            .cp_two     (cp_two_i[k]),
            .cp_five    (cp_five_i[k]),
            .q          (val),
            .carry_fall (carry[k])
        );

        assign q_o[k] = val;
    end

endmodule

// File: tb/sim_dsdc_top.sv
module sim_dsdc_top;
    localparam int N      = 3;
    localparam int SETTLE = 14;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [N-1:0]       cp_two = '0;
    logic [N-1:0]       cp_five = '0;
    logic [N-1:0]       clr_n = '1;
    logic [N-1:0][1:0]  link = '0;
    logic               chain = 1'b0;
    logic [N-1:0][3:0]  q;

    dsdc_top #(.NUM_CTR(N)) u0 (
        .clk(clk), .rst(rst), .cp_two_i(cp_two), .cp_five_i(cp_five),
        .clr_n_i(clr_n), .link_i(link), .chain_i(chain), .q_o(q)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    bit req   = 0;
    logic [N*4-1:0] exp_q[$];
    string          tag_q[$];

    int m_two [N];
    int m_five[N];

    function automatic logic [N*4-1:0] model_vec();
        logic [N*4-1:0] v;
        for (int k = 0; k < N; k++) v[k*4 +: 4] = {3'(m_five[k]), m_two[k][0]};
        return v;
    endfunction

    function automatic void model_zero();
        for (int k = 0; k < N; k++) begin
            m_two[k]  = 0;
            m_five[k] = 0;
        end
    endfunction

    // expected effect of one falling edge on an external input
    function automatic void model_ext(int k, bit five_sec);
        int cur;
        bit sec, go, carry, fl, wrap;
        if (!clr_n[k]) return;
        if (chain && k > 0 && five_sec == (link[k] == 2'd2)) return;
        if (link[k] == 2'd2 && !five_sec) return;
        if (link[k] == 2'd1 && five_sec) return;
        cur = k; sec = five_sec; go = 1;
        while (go) begin
            carry = 0;
            if (!sec) begin
                fl = (m_two[cur] == 1);
                m_two[cur] ^= 1;
                if (link[cur] == 2'd2) carry = fl;
                else if (link[cur] == 2'd1 && fl) begin
                    carry = (m_five[cur] == 4);
                    m_five[cur] = (m_five[cur] + 1) % 5;
                end
            end else begin
                wrap = (m_five[cur] == 4);
                m_five[cur] = (m_five[cur] + 1) % 5;
                if (link[cur] == 2'd2) begin
                    if (wrap) begin
                        fl = (m_two[cur] == 1);
                        m_two[cur] ^= 1;
                        carry = fl;
                    end
                end else carry = wrap;
            end
            if (carry && chain && cur + 1 < N) begin
                cur++;
                sec = (link[cur] == 2'd2);
            end else go = 0;
        end
    endfunction

    // monitor: pops and compares at the negedge after a request
    initial begin
        forever begin
            @(negedge clk);
            if (req) begin
                logic [N*4-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (q !== e) begin
                    n_bad++;
                    $display("FAIL %s: q=%h expected %h", t, q, e);
                end
                req = 0;
            end
        end
    end

    task automatic request(logic [N*4-1:0] e, string t);
        @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        req = 1;
        wait (req == 0);
    endtask

    task automatic pulse(int k, bit five_sec, string t);
        @(negedge clk);
        if (five_sec) cp_five[k] = 1'b1; else cp_two[k] = 1'b1;
        repeat (3) @(negedge clk);
        if (five_sec) cp_five[k] = 1'b0; else cp_two[k] = 1'b0;
        repeat (SETTLE) @(negedge clk);
        model_ext(k, five_sec);
        request(model_vec(), t);
    endtask

    task automatic setup(logic [N-1:0][1:0] lk, bit ch);
        @(negedge clk);
        rst = 1'b1; link = lk; chain = ch;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_zero();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: q=%h expected completion", q);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_zero();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        request('0, "R1 reset");

        // split order on counter 1, others idle
        setup('0, 1'b0);
        for (int i = 0; i < 3; i++) pulse(1, 1'b0, "R2 two-section toggle");
        for (int i = 0; i < 6; i++) pulse(1, 1'b1, "R3 five-section wrap");

        // link code 3 on counter 2
        setup({2'd3, 2'd0, 2'd0}, 1'b0);
        for (int i = 0; i < 3; i++) pulse(2, 1'b1, "R9 code 3 five");
        pulse(2, 1'b0, "R9 code 3 two");

        // latency of one transition
        setup('0, 1'b0);
        @(negedge clk); cp_two[0] = 1'b1;
        repeat (3) @(negedge clk); cp_two[0] = 1'b0;
        request('0, "R4 first edge unchanged");
        m_two[0] = 1;
        request(model_vec(), "R4 second edge");

        // decade order on counter 0
        setup({2'd0, 2'd0, 2'd1}, 1'b0);
        for (int i = 0; i < 12; i++) pulse(0, 1'b0, "R5 BCD sequence");
        pulse(0, 1'b1, "R5 ignored five input");

        // biquinary order on counter 1
        setup({2'd0, 2'd2, 2'd0}, 1'b0);
        for (int i = 0; i < 11; i++) pulse(1, 1'b1, "R6 biquinary sequence");
        pulse(1, 1'b0, "R6 ignored two input");

        // chained decades
        setup({2'd1, 2'd1, 2'd1}, 1'b1);
        for (int i = 0; i < 101; i++) pulse(0, 1'b0, "R8 decade chain");
        pulse(1, 1'b0, "R8 ignored entry input");

        // decade into biquinary
        setup({2'd0, 2'd2, 2'd1}, 1'b1);
        for (int i = 0; i < 25; i++) pulse(0, 1'b0, "R8 decade into biquinary");

        // clear and truncation
        setup({2'd0, 2'd1, 2'd1}, 1'b0);
        for (int i = 0; i < 6; i++) pulse(0, 1'b0, "R7 pre-clear count");
        for (int i = 0; i < 3; i++) pulse(1, 1'b0, "R7 pre-clear other");
        @(negedge clk); clr_n[0] = 1'b0;
        #2;
        n_chk++;
        if (q[0] !== 4'd0) begin
            n_bad++;
            $display("FAIL R7 immediate clear: q=%h expected 0", q[0]);
        end
        m_two[0] = 0; m_five[0] = 0;
        request(model_vec(), "R7 cleared, other kept");
        pulse(0, 1'b0, "R7 pulse during clear ignored");
        @(negedge clk); clr_n[0] = 1'b1;
        repeat (3) @(negedge clk);
        pulse(0, 1'b0, "R7 count after release");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule